// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block keeps the single reservation that one processor needs for load-reserved and store-conditional instructions, and it owns a small local memory that those instructions access. A load-reserved command reads memory and arms a lock flag for the region that holds the address. Every bus cycle that another agent puts on the snoop port is compared with that region. A hit drops the flag.

A later store-conditional writes memory only while the flag is still armed and the store falls in the reserved region. It reports the outcome as a success bit and always disarms the flag afterwards. Software builds atomic exchange, fetch-and-op and compare-and-swap by retrying the pair until the store succeeds. Commands carry a size of 4 or 8 bytes. Accesses that are not naturally aligned are rejected with an error.

Top module: `llsc_monitor`

## Requirements
- R1: An aligned load-reserved (`cmd_op`=0) arms `resv_flag`, records the granule of `cmd_addr`, and returns the memory contents at `cmd_addr` on `rsp_rdata`.
- R2: A snoop (`snp_valid`) whose address has the same granule bits (`addr[7:4]` by default, 16-byte granule) as the reservation clears `resv_flag`. A snoop to any other granule leaves it armed.
- R3: An aligned store-conditional (`cmd_op`=1) writes `cmd_wdata` to memory only when the flag is armed. Otherwise memory is unchanged.
- R4: A store-conditional reports `rsp_ok`=1 exactly when it wrote and `rsp_ok`=0 otherwise. It leaves `resv_flag` at 0 whatever its outcome.
- R5: With `cmd_size`=0 (4 bytes) `cmd_addr[1:0]` must be 0, and with `cmd_size`=1 (8 bytes) `cmd_addr[2:0]` must be 0. A misaligned command of either kind returns `rsp_misalign`=1, `rsp_ok`=0 and `rsp_rdata`=0, writes nothing, and clears `resv_flag`.
- R6: A new aligned load-reserved replaces any earlier reservation. This holds even when a snoop to the same granule arrives in the same cycle.
- R7: A store-conditional whose granule differs from the reserved one fails and writes nothing, even while the flag is armed.
- R8: When a snoop hit and a store-conditional fall in the same cycle, the snoop takes priority: the store fails and writes nothing.
- R9: Each command is answered with `rsp_valid`=1 for exactly one cycle, on the clock edge after the one that accepts it. Without a command `rsp_valid` is 0.
- R10: A 4-byte access uses bits 31:0 of the 8-byte word when `cmd_addr[2]`=0 and bits 63:32 when it is 1. Reads are zero-extended. A 4-byte store changes only that half, using `cmd_wdata[31:0]`.
- R11: While `rst` is high, and right after it falls, `resv_flag` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = load-reserved, 1 = store-conditional |
| cmd_size | input | 1 | 0 = 4 bytes, 1 = 8 bytes |
| cmd_addr | input | ADDR_W | Byte address of the command |
| cmd_wdata | input | 64 | Store data |
| snp_valid | input | 1 | Bus cycle by another agent observed |
| snp_addr | input | ADDR_W | Byte address of the observed bus cycle |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 64 | Load data (zero for stores and errors) |
| rsp_ok | output | 1 | Store-conditional succeeded |
| rsp_misalign | output | 1 | Command was misaligned |
| resv_flag | output | 1 | Reservation currently armed |

## Verification
Every result of the block is due exactly one clock edge after the command or snoop that causes it. The response fields, the read data from the synchronous memory and the new state of the reservation flag all settle on that same edge. The bench drives each stimulus on a falling edge and samples on the next falling edge, so it observes the state one rising edge later. A reference model in the bench updates its own memory image and flag with the same one-step latency. Memory writes are confirmed by later load-reserved reads and never by looking inside the design.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic {
    OP_LOAD_RES  = 1'b0,
    OP_STORE_CND = 1'b1
  } llsc_op_e;

  typedef enum logic {
    SZ_WORD  = 1'b0,
    SZ_DWORD = 1'b1
  } llsc_size_e;

  localparam int unsigned LANE_W = 32;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANE_W * LANES;
  localparam int unsigned WORD_LG = 3;
endpackage

// File: rtl/llsc_align.sv
module llsc_align #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              size_dw,
  input  logic [ADDR_W-1:0] addr,
  output logic              misaligned
);
  logic [ADDR_W-1:0] low_unused;
  assign low_unused = addr;
  always_comb begin
    if (size_dw) misaligned = |addr[2:0];
    else         misaligned = |addr[1:0];
  end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int unsigned GRAN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lr_arm,
  input  logic              drop_now,
  input  logic [GRAN_W-1:0] cmd_gran,
  input  logic              snp_valid,
  input  logic [GRAN_W-1:0] snp_gran,
  output logic              flag,
  output logic [GRAN_W-1:0] gran,
  output logic              sc_pass
);
  logic snoop_hit;

  assign snoop_hit = snp_valid && flag && (snp_gran == gran);
  assign sc_pass   = flag && (cmd_gran == gran) && !snoop_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      gran <= '0;
    end else if (lr_arm) begin
      flag <= 1'b1;
      gran <= cmd_gran;
    end else if (drop_now || snoop_hit) begin
      flag <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
  parameter int unsigned IDX_W = 5
) (
  input  logic                              clk,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [llsc_pkg::LANES-1:0]        lane_we,
  input  logic [llsc_pkg::DATA_W-1:0]       wdata,
  output logic [llsc_pkg::DATA_W-1:0]       rdata
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned LW    = llsc_pkg::LANE_W;

  for (genvar l = 0; l < int'(llsc_pkg::LANES); l++) begin : g_lane
    logic [LW-1:0] ram [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[l]) ram[idx] <= wdata[l*LW +: LW];
      rdata[l*LW +: LW] <= ram[idx];
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned GRAN_LG = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic                        cmd_op,
  input  logic                        cmd_size,
  input  logic [ADDR_W-1:0]           cmd_addr,
  input  logic [llsc_pkg::DATA_W-1:0] cmd_wdata,
  input  logic                        snp_valid,
  input  logic [ADDR_W-1:0]           snp_addr,
  output logic                        rsp_valid,
  output logic [llsc_pkg::DATA_W-1:0] rsp_rdata,
  output logic                        rsp_ok,
  output logic                        rsp_misalign,
  output logic                        resv_flag
);
  import llsc_pkg::*;

  localparam int unsigned GRAN_W = ADDR_W - GRAN_LG;
  localparam int unsigned IDX_W  = ADDR_W - WORD_LG;

  llsc_op_e   op;
  llsc_size_e sz;
  logic       misaligned;
  logic       do_lr, do_sc, sc_pass, sc_write;
  logic [GRAN_W-1:0] resv_gran;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] wr_data, rd_word;
  logic [GRAN_LG-1:0] snp_unused;

  assign op = llsc_op_e'(cmd_op);
  assign sz = llsc_size_e'(cmd_size);
  assign snp_unused = snp_addr[GRAN_LG-1:0];

  llsc_align #(.ADDR_W(ADDR_W)) u_align (
    .size_dw   (sz == SZ_DWORD),
    .addr      (cmd_addr),
    .misaligned(misaligned)
  );

  assign do_lr = cmd_valid && (op == OP_LOAD_RES)  && !misaligned;
  assign do_sc = cmd_valid && (op == OP_STORE_CND) && !misaligned;

  llsc_resv #(.GRAN_W(GRAN_W)) u_resv (
    .clk      (clk),
    .rst      (rst),
    .lr_arm   (do_lr),
    .drop_now (do_sc || (cmd_valid && misaligned)),
    .cmd_gran (cmd_addr[ADDR_W-1:GRAN_LG]),
    .snp_valid(snp_valid),
    .snp_gran (snp_addr[ADDR_W-1:GRAN_LG]),
    .flag     (resv_flag),
    .gran     (resv_gran),
    .sc_pass  (sc_pass)
  );

  assign sc_write = do_sc && sc_pass;

  always_comb begin
    if (sz == SZ_DWORD) begin
      lane_we = {LANES{sc_write}};
      wr_data = cmd_wdata;
    end else begin
      lane_we = '0;
      lane_we[cmd_addr[2]] = sc_write;
      wr_data = {LANES{cmd_wdata[LANE_W-1:0]}};
    end
  end

  llsc_mem #(.IDX_W(IDX_W)) u_mem (
    .clk    (clk),
    .idx    (cmd_addr[ADDR_W-1:WORD_LG]),
    .lane_we(lane_we),
    .wdata  (wr_data),
    .rdata  (rd_word)
  );

  logic q_lr, q_dw, q_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_ok       <= 1'b0;
      rsp_misalign <= 1'b0;
      q_lr         <= 1'b0;
      q_dw         <= 1'b0;
      q_hi         <= 1'b0;
    end else begin
      rsp_valid    <= cmd_valid;
      rsp_ok       <= sc_write;
      rsp_misalign <= cmd_valid && misaligned;
      q_lr         <= do_lr;
      q_dw         <= (sz == SZ_DWORD);
      q_hi         <= cmd_addr[2];
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (q_lr) begin
      if (q_dw)      rsp_rdata = rd_word;
      else if (q_hi) rsp_rdata[LANE_W-1:0] = rd_word[DATA_W-1:LANE_W];
      else           rsp_rdata[LANE_W-1:0] = rd_word[LANE_W-1:0];
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned GRAN_LG = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cmd_valid,
  input logic                     cmd_op,
  input logic                     cmd_size,
  input logic [ADDR_W-1:0]        cmd_addr,
  input logic                     snp_valid,
  input logic [ADDR_W-1:0]        snp_addr,
  input logic                     rsp_valid,
  input logic                     rsp_ok,
  input logic                     rsp_misalign,
  input logic                     resv_flag,
  input logic [ADDR_W-GRAN_LG-1:0] resv_gran
);
  logic aligned, snp_match;
  assign aligned   = cmd_size ? (cmd_addr[2:0] == 3'd0) : (cmd_addr[1:0] == 2'd0);
  assign snp_match = snp_valid && resv_flag && (snp_addr[ADDR_W-1:GRAN_LG] == resv_gran);

  p_lr_arms_r1: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_op && aligned |=> resv_flag);
  p_snoop_drops_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid && snp_match |=> !resv_flag);
  p_ok_needs_flag_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op && !resv_flag |=> !rsp_ok);
  p_sc_drops_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op |=> !resv_flag);
  p_misalign_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !aligned |=> rsp_misalign && !rsp_ok && !resv_flag);
  p_outside_fails_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op && (cmd_addr[ADDR_W-1:GRAN_LG] != resv_gran) |=> !rsp_ok);
  p_snoop_wins_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op && snp_match |=> !rsp_ok);
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);
  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid && !rsp_ok && !rsp_misalign);
endmodule

bind llsc_monitor llsc_monitor_chk #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_size(cmd_size),
  .cmd_addr(cmd_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_misalign(rsp_misalign),
  .resv_flag(resv_flag), .resv_gran(resv_gran)
);

// File: tb/llsc_monitor_tb.sv
`timescale 1ns/1ps
module llsc_monitor_tb;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 0, cmd_op = 0, cmd_size = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [63:0] cmd_wdata = '0;
  logic snp_valid = 0;
  logic [AW-1:0] snp_addr = '0;
  logic rsp_valid, rsp_ok, rsp_misalign, resv_flag;
  logic [63:0] rsp_rdata;

  always #4 clk = ~clk;

  llsc_monitor #(.ADDR_W(AW), .GRAN_LG(4)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_size(cmd_size),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_ok(rsp_ok),
    .rsp_misalign(rsp_misalign), .resv_flag(resv_flag)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0, chk_data = 0;
  logic [63:0] m_mem [32];
  bit m_flag = 0;
  logic [3:0] m_gran = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input bit v, input bit op, input bit sz, input logic [7:0] a,
                       input logic [63:0] wd, input bit sv, input logic [7:0] sa,
                       input string tag);
    bit mis, hit, ok;
    logic [63:0] exp_d;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_size = sz; cmd_addr = a; cmd_wdata = wd;
    snp_valid = sv; snp_addr = sa;
    mis = sz ? (a[2:0] != 0) : (a[1:0] != 0);
    hit = sv && m_flag && (sa[7:4] == m_gran);
    ok = 0; exp_d = '0;
    if (v && mis) m_flag = 0;
    else if (v && !op) begin
      exp_d = sz ? m_mem[a[7:3]] : (a[2] ? {32'd0, m_mem[a[7:3]][63:32]}
                                         : {32'd0, m_mem[a[7:3]][31:0]});
      m_flag = 1; m_gran = a[7:4];
    end else if (v && op) begin
      ok = m_flag && (a[7:4] == m_gran) && !hit;
      if (ok) begin
        if (sz) m_mem[a[7:3]] = wd;
        else if (a[2]) m_mem[a[7:3]][63:32] = wd[31:0];
        else m_mem[a[7:3]][31:0] = wd[31:0];
      end
      m_flag = 0;
    end else if (hit) m_flag = 0;
    @(negedge clk);
    cmd_valid = 0; snp_valid = 0;
    check({tag, " rsp_valid R9"}, 64'(rsp_valid), 64'(v));
    check({tag, " resv_flag"}, 64'(resv_flag), 64'(m_flag));
    if (v) begin
      check({tag, " misalign R5"}, 64'(rsp_misalign), 64'(mis));
      check({tag, " ok R4"}, 64'(rsp_ok), 64'(ok));
      if (chk_data || op || mis) check({tag, " rdata R1/R10"}, rsp_rdata, exp_d);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset flag", 64'(resv_flag), 0);
    check("R11 reset rsp_valid", 64'(rsp_valid), 0);
    rst = 0;
    @(negedge clk);
    check("R11 after reset flag", 64'(resv_flag), 0);
    check("R11 after reset rsp_valid", 64'(rsp_valid), 0);

    // fill memory with LR/SC pairs (R3)
    for (int w = 0; w < 32; w++) begin
      apply(1, 0, 1, 8'(w*8), 0, 0, 0, "R1 init lr");
      apply(1, 1, 1, 8'(w*8), {8'(w), 24'h5a5a5a, 8'(~w), 24'hc3c3c3}, 0, 0, "R3 init sc");
    end
    chk_data = 1;

    // alignment and read sweep over every address and size (R5 R10 R6)
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 2; s++)
        apply(1, 0, s[0], 8'(a), 0, 0, 0, "R5 R10 lr sweep");

    // snoop sweep (R2 R3): only a snoop into the reserved granule breaks the pair
    for (int g = 0; g < 16; g++)
      for (int k = 0; k < 16; k++) begin
        apply(1, 0, k[0], 8'(g*16 + (k[3] ? 8 : 0) + (k[0] ? 0 : 4)), 0, 0, 0, "R1 lr");
        apply(0, 0, 0, 0, 0, 1, 8'(((g + k) % 16) * 16 + k), "R2 snoop");
        apply(1, 1, k[0], 8'(g*16 + (k[3] ? 8 : 0) + (k[0] ? 0 : 4)),
              {16'(g), 16'(k), 32'(g*k + 7)}, 0, 0, "R3 sc after snoop");
      end

    // SC with no reservation, and a second SC after success (R4)
    apply(1, 1, 1, 8'h10, 64'h1111, 0, 0, "R4 sc no resv");
    apply(1, 0, 1, 8'h10, 0, 0, 0, "R1 lr");
    apply(1, 1, 1, 8'h10, 64'h2222, 0, 0, "R4 sc first");
    apply(1, 1, 1, 8'h10, 64'h3333, 0, 0, "R4 sc second");
    apply(1, 0, 1, 8'h10, 0, 0, 0, "R3 readback");

    // SC outside reserved granule (R7)
    apply(1, 0, 1, 8'h20, 0, 0, 0, "R1 lr");
    apply(1, 1, 1, 8'h30, 64'hdead, 0, 0, "R7 sc outside");
    apply(1, 0, 1, 8'h30, 0, 0, 0, "R7 readback");

    // snoop and SC in the same cycle (R8)
    apply(1, 0, 0, 8'h44, 0, 0, 0, "R1 lr");
    apply(1, 1, 0, 8'h44, 64'hbeef, 1, 8'h4c, "R8 race");
    apply(1, 0, 1, 8'h40, 0, 0, 0, "R8 readback");

    // misaligned SC while armed (R5)
    apply(1, 0, 1, 8'h50, 0, 0, 0, "R1 lr");
    apply(1, 1, 1, 8'h54, 64'hf00d, 0, 0, "R5 sc misaligned");
    apply(1, 1, 1, 8'h50, 64'hf00d, 0, 0, "R5 sc after misalign");
    apply(1, 0, 1, 8'h50, 0, 0, 0, "R5 readback");

    // LR beside a same-granule snoop, and replacement (R6)
    apply(1, 0, 1, 8'h68, 0, 1, 8'h60, "R6 lr with snoop");
    apply(1, 1, 1, 8'h68, 64'h6868, 0, 0, "R6 sc ok");
    apply(1, 0, 1, 8'h60, 0, 0, 0, "R6 lr old");
    apply(1, 0, 1, 8'h70, 0, 0, 0, "R6 lr new");
    apply(1, 1, 1, 8'h60, 64'h6060, 0, 0, "R6 sc old granule");
    apply(1, 0, 1, 8'h60, 0, 0, 0, "R6 lr old again");
    apply(1, 0, 1, 8'h78, 0, 0, 0, "R6 lr replace");
    apply(1, 1, 0, 8'h7c, 64'h7c7c, 0, 0, "R6 R10 sc half");

    // final read of every word (R3 R10)
    for (int w = 0; w < 32; w++)
      apply(1, 0, 1, 8'(w*8), 0, 0, 0, "R3 final readback");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule